// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This block sits between a bus master and a memory port. It recognises two address windows in which every 32-bit alias word stands for one bit of ordinary memory. A read in a window returns that bit alone, as 0 or 1. A write in a window becomes a read-modify-write of the byte, halfword or word that holds the bit. Only that one bit changes. Any address outside the windows is forwarded to memory unchanged, as a single transaction.

Both sides use valid/ready request handshakes. On the slave side the master raises `s_valid` with stable address, size and data, and holds them until it sees `s_ready` high at a clock edge. The bridge pulses `s_rsp_valid` for one cycle per accepted request, and this pulse cannot be back-pressured. On the memory side the bridge holds `m_valid` and every request field stable until `m_ready` is high at an edge. Memory must answer each accepted request, read or write, with exactly one `m_rsp_valid` pulse in a later cycle. Only one request is outstanding at any time.

Memory is little-endian on a 32-bit data bus. Byte lane k carries address offset k, so the byte at offset k occupies bits 8k+7 to 8k. Size encoding on both ports: 0 = byte, 1 = halfword, 2 = word.

Top module: `bba_bridge`

## Requirements
- R1: An address is an alias when bits 31:25 equal those of 0x22000000 or of 0x42000000, so each window spans 32 MB. Every other address, including 0x21FFFFFC and 0x24000000, is not an alias.
- R2: The memory address of an alias access is built from two parts. Bits 31:29 are copied from the alias address. The rest is the alias address masked with 0x1FFFFFF and shifted right by 5.
- R3: The selected bit within the accessed unit is found by shifting the alias address right by 2. The result is then limited to 3 bits for a byte, 4 bits for a halfword and 5 bits for a word. On the 32-bit memory bus that bit sits at 8 × (byte offset of the unit) + index.
- R4: The memory address of a halfword alias access has bit 0 cleared. The memory address of a word alias access has bits 1:0 cleared.
- R5: An alias read issues exactly one memory read at the access size. Its response data is 1 when the selected bit is set and 0 when it is clear, and all other bits are zero.
- R6: An alias write issues a memory read and then a memory write to the same address at the same size. The written data equals the data read, with only the selected bit changed.
- R7: An alias write sets the selected bit when write-data bit 0 is 1 and clears it when bit 0 is 0. All other write-data bits are ignored.
- R8: From the cycle a request is accepted until its response pulse, `s_ready` stays low. No other memory traffic takes place in that time, so the read-modify-write cannot be split.
- R9: A non-alias request is forwarded with the same address, direction, size and write data, as exactly one memory transaction. Its memory response data is returned on the slave port.
- R10: Reset puts the bridge back to idle, drops `m_valid` and `s_rsp_valid`, and abandons any half-finished sequence without a write-back.
- R11: While memory holds `m_ready` low, the bridge keeps `m_valid` high and keeps its request fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Master request valid |
| s_ready | output | 1 | Bridge accepts request at this edge |
| s_addr | input | 32 | Request byte address |
| s_we | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_wdata | input | 32 | Write data |
| s_rsp_valid | output | 1 | One-cycle response pulse |
| s_rdata | output | 32 | Response read data |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory accepts request at this edge |
| m_addr | output | 32 | Memory byte address |
| m_we | output | 1 | Memory write enable |
| m_size | output | 2 | Memory access size |
| m_wdata | output | 32 | Memory write data |
| m_rsp_valid | input | 1 | Memory response pulse |
| m_rdata | input | 32 | Memory read data, all four lanes of the aligned word |

## Verification
Two things can happen in the same cycle: the response pulse for one request, and the master presenting its next request. The bench raises every new request in the very cycle it sees the previous response, so the two always overlap. It judges the result by requiring that `s_ready` stays low until the bridge is idle again. It also counts the memory transactions between acceptance and response, and checks their read/write order. The stimulus table is run a second time while memory drops `m_ready` every fourth cycle. This makes the end of a write-back handshake coincide with a stalled request, and the bit values must come out the same as in the first run.

// File: rtl/bba_pkg.sv
package bba_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP,
    ST_PASS
  } bba_state_e;

endpackage

// File: rtl/bba_decode.sv
module bba_decode
  import bba_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NUM_WIN = 2,
  parameter int WIN_LOG2 = 25,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASES = {32'h4200_0000, 32'h2200_0000}
) (
  input  logic [AW-1:0]          addr,
  input  logic [1:0]             size,
  output logic                   hit,
  output logic [AW-1:0]          tgt_addr,
  output logic [$clog2(DW)-1:0]  lane_bit
);
  localparam int BIT_W = $clog2(DW);
  localparam int TOP_W = 3;
  localparam int SHIFT = 5;   // 8 bits per byte, 4 alias bytes per bit
  localparam int KEEP_W = WIN_LOG2 - SHIFT;
  localparam int PAD_W = AW - TOP_W - KEEP_W;

  logic [NUM_WIN-1:0] win_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w] = (addr[AW-1:WIN_LOG2] == WIN_BASES[w*AW+WIN_LOG2 +: AW-WIN_LOG2]);
  end

  assign hit = |win_hit;

  logic [AW-1:0]    raw_tgt;
  logic [BIT_W-1:0] idx;
  logic [1:0]       lane_off;

  assign raw_tgt = {addr[AW-1 -: TOP_W], {PAD_W{1'b0}}, addr[WIN_LOG2-1:SHIFT]};

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        tgt_addr = raw_tgt;
        idx      = BIT_W'(addr[4:2]);
        lane_off = raw_tgt[1:0];
      end
      SZ_HALF: begin
        tgt_addr = {raw_tgt[AW-1:1], 1'b0};
        idx      = BIT_W'(addr[5:2]);
        lane_off = {raw_tgt[1], 1'b0};
      end
      default: begin
        tgt_addr = {raw_tgt[AW-1:2], 2'b00};
        idx      = addr[BIT_W+1:2];
        lane_off = 2'b00;
      end
    endcase
  end

  assign lane_bit = BIT_W'({lane_off, 3'b000}) + idx;

  logic unused_low;
  assign unused_low = ^addr[1:0];

endmodule

// File: rtl/bba_bitops.sv
module bba_bitops #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          word,
  input  logic [$clog2(DW)-1:0]  bit_sel,
  input  logic                   set_val,
  output logic                   bit_val,
  output logic [DW-1:0]          merged
);
  logic [DW-1:0] mask;

  assign mask    = DW'(1) << bit_sel;
  assign bit_val = |(word & mask);
  assign merged  = set_val ? (word | mask) : (word & ~mask);

  always_comb begin
    a_r3_single_lane_bit: assert ($onehot(mask))
      else $error("mask must select exactly one bit");
  end

endmodule

// File: rtl/bba_bridge.sv
module bba_bridge
  import bba_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NUM_WIN = 2,
  parameter int WIN_LOG2 = 25,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASES = {32'h4200_0000, 32'h2200_0000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [AW-1:0] s_addr,
  input  logic          s_we,
  input  logic [1:0]    s_size,
  input  logic [DW-1:0] s_wdata,
  output logic          s_rsp_valid,
  output logic [DW-1:0] s_rdata,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic          m_we,
  output logic [1:0]    m_size,
  output logic [DW-1:0] m_wdata,
  input  logic          m_rsp_valid,
  input  logic [DW-1:0] m_rdata
);
  localparam int BIT_W = $clog2(DW);

  logic             dec_hit;
  logic [AW-1:0]    dec_tgt;
  logic [BIT_W-1:0] dec_bit;

  bba_decode #(
    .AW(AW), .DW(DW), .NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2), .WIN_BASES(WIN_BASES)
  ) u_dec (
    .addr     (s_addr),
    .size     (s_size),
    .hit      (dec_hit),
    .tgt_addr (dec_tgt),
    .lane_bit (dec_bit)
  );

  bba_state_e       state, state_nx;
  logic [AW-1:0]    lat_tgt;
  logic [1:0]       lat_size;
  logic             lat_we;
  logic             lat_set;
  logic [BIT_W-1:0] lat_bit;
  logic [DW-1:0]    wb_q;
  logic [DW-1:0]    resp_q;

  logic             op_bit;
  logic [DW-1:0]    op_merged;

  bba_bitops #(.DW(DW)) u_bits (
    .word    (m_rdata),
    .bit_sel (lat_bit),
    .set_val (lat_set),
    .bit_val (op_bit),
    .merged  (op_merged)
  );

  always_comb begin
    state_nx    = state;
    s_ready     = 1'b0;
    s_rsp_valid = 1'b0;
    s_rdata     = resp_q;
    m_valid     = 1'b0;
    m_addr      = lat_tgt;
    m_we        = 1'b0;
    m_size      = lat_size;
    m_wdata     = wb_q;
    unique case (state)
      ST_IDLE: begin
        m_addr  = s_addr;
        m_size  = s_size;
        m_we    = s_we;
        m_wdata = s_wdata;
        if (dec_hit) begin
          s_ready = 1'b1;
          if (s_valid) state_nx = ST_RD_REQ;
        end else begin
          s_ready = m_ready;
          m_valid = s_valid;
          if (s_valid && m_ready) state_nx = ST_PASS;
        end
      end
      ST_RD_REQ: begin
        m_valid = 1'b1;
        if (m_ready) state_nx = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (m_rsp_valid) state_nx = lat_we ? ST_WR_REQ : ST_RESP;
      end
      ST_WR_REQ: begin
        m_valid = 1'b1;
        m_we    = 1'b1;
        if (m_ready) state_nx = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (m_rsp_valid) state_nx = ST_RESP;
      end
      ST_RESP: begin
        s_rsp_valid = 1'b1;
        state_nx    = ST_IDLE;
      end
      ST_PASS: begin
        s_rsp_valid = m_rsp_valid;
        s_rdata     = m_rdata;
        if (m_rsp_valid) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lat_tgt  <= '0;
      lat_size <= SZ_BYTE;
      lat_we   <= 1'b0;
      lat_set  <= 1'b0;
      lat_bit  <= '0;
      wb_q     <= '0;
      resp_q   <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && s_valid && dec_hit) begin
        lat_tgt  <= dec_tgt;
        lat_size <= s_size;
        lat_we   <= s_we;
        lat_set  <= s_wdata[0];
        lat_bit  <= dec_bit;
      end
      if (state == ST_RD_WAIT && m_rsp_valid) begin
        wb_q   <= op_merged;
        resp_q <= DW'(op_bit);
      end
      if (state == ST_WR_WAIT && m_rsp_valid) begin
        resp_q <= '0;
      end
    end
  end

  // R8: nothing else is accepted while a sequence is in flight
  a_r8_busy_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !s_ready);

  // R11: a stalled memory request keeps its contents
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RD_REQ || state == ST_WR_REQ) && !m_ready)
      |=> (m_valid && $stable(m_addr) && $stable(m_we) && $stable(m_size) && $stable(m_wdata)));

  // R5: an alias read answers with a lone bit
  a_r5_read_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rsp_valid && state == ST_RESP && !lat_we) |-> (s_rdata[DW-1:1] == '0));

  // R6: read phase is a read, write-back carries the requested bit value
  a_r6_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_REQ) |-> (m_valid && !m_we));

  a_r6_wb_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_REQ) |-> (m_we && m_wdata[lat_bit] == lat_set));

  a_r6_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_WAIT && m_rsp_valid && lat_we) |=> (state == ST_WR_REQ));

  // R9: a forwarded request produces one transaction only
  a_r9_pass_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PASS) |-> !m_valid);

  // R10: idle with no request means no traffic on either side
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !s_valid) |-> (!m_valid && !s_rsp_valid));

endmodule

// File: tb/tb_bba_bridge.sv
module tb_bba_bridge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid;
  logic        s_ready;
  logic [31:0] s_addr;
  logic        s_we;
  logic [1:0]  s_size;
  logic [31:0] s_wdata;
  logic        s_rsp_valid;
  logic [31:0] s_rdata;
  logic        m_valid;
  logic        m_ready;
  logic [31:0] m_addr;
  logic        m_we;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic        m_rsp_valid;
  logic [31:0] m_rdata;

  always #5 clk = ~clk;

  bba_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_we(s_we),
    .s_size(s_size), .s_wdata(s_wdata), .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_we(m_we),
    .m_size(m_size), .m_wdata(m_wdata), .m_rsp_valid(m_rsp_valid), .m_rdata(m_rdata)
  );

  // ---------------- memory model: little-endian, one-cycle response ----------
  logic [7:0]  mem [0:2047];
  logic        mrsp;
  logic [31:0] mrdata;
  int          txn_cnt = 0;
  logic        txn_we_log [0:255];
  logic [1:0]  cyc = '0;
  logic        stall_mode = 1'b0;

  function automatic int midx(logic [31:0] a);
    return int'({a[30], a[9:0]});
  endfunction

  assign m_ready     = !stall_mode || (cyc != 2'd0);
  assign m_rsp_valid = mrsp;
  assign m_rdata     = mrdata;

  always @(posedge clk) cyc <= cyc + 2'd1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrsp   <= 1'b0;
      mrdata <= '0;
    end else begin
      mrsp <= 1'b0;
      if (m_valid && m_ready) begin
        txn_we_log[txn_cnt[7:0]] <= m_we;
        txn_cnt <= txn_cnt + 1;
        mrsp    <= 1'b1;
        if (m_we) begin
          for (int k = 0; k < 4; k++) begin
            if ((m_size == 2'd2) ||
                (m_size == 2'd1 && 1'(k >> 1) == m_addr[1]) ||
                (m_size == 2'd0 && 2'(k) == m_addr[1:0]))
              mem[midx({m_addr[31:2], 2'(k)})] <= m_wdata[8*k +: 8];
          end
        end else begin
          mrdata <= {mem[midx({m_addr[31:2], 2'd3})], mem[midx({m_addr[31:2], 2'd2})],
                     mem[midx({m_addr[31:2], 2'd1})], mem[midx({m_addr[31:2], 2'd0})]};
        end
      end
    end
  end

  // ---------------- bookkeeping ------------------------------------------------
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where the response is seen
  task automatic run_op(input logic [31:0] a, input logic w, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] rd, output int ntx,
                        output logic we0, output logic we1, output bit leak);
    int start;
    start = txn_cnt;
    leak  = 1'b0;
    s_valid = 1'b1; s_addr = a; s_we = w; s_size = sz; s_wdata = d;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (s_rsp_valid) break;
      if (s_ready) leak = 1'b1;
    end
    rd  = s_rdata;
    ntx = txn_cnt - start;
    we0 = txn_we_log[start[7:0]];
    we1 = txn_we_log[8'(start + 1)];
  endtask

  // ---------------- vector table ------------------------------------------------
  typedef struct packed {
    logic [31:0] addr;
    logic        we;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [1:0]  ntx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    // R9 plain writes that set up memory; R1 edges just outside window 0
    '{32'h2000_0010, 1'b1, 2'd2, 32'hA5C3_0F81, 1'b0, 32'h0, 2'd1, 4'd9},
    '{32'h4000_0020, 1'b1, 2'd2, 32'h00FF_00F0, 1'b0, 32'h0, 2'd1, 4'd9},
    '{32'h2400_0000, 1'b1, 2'd2, 32'h1234_5678, 1'b0, 32'h0, 2'd1, 4'd1},
    '{32'h21FF_FFFC, 1'b1, 2'd2, 32'hCAFE_F00D, 1'b0, 32'h0, 2'd1, 4'd1},
    // R2 R5 byte alias reads of 0x20000010 (0x81) and 0x20000011 (0x0F)
    '{32'h2200_0200, 1'b0, 2'd0, 32'h0, 1'b1, 32'h1, 2'd1, 4'd2},
    '{32'h2200_0204, 1'b0, 2'd0, 32'h0, 1'b1, 32'h0, 2'd1, 4'd5},
    '{32'h2200_021C, 1'b0, 2'd0, 32'h0, 1'b1, 32'h1, 2'd1, 4'd5},
    '{32'h2200_022C, 1'b0, 2'd0, 32'h0, 1'b1, 32'h1, 2'd1, 4'd3},
    '{32'h2200_0230, 1'b0, 2'd0, 32'h0, 1'b1, 32'h0, 2'd1, 4'd3},
    // R4 R3 halfword alias reads of 0x20000012 (0xA5C3)
    '{32'h2200_027C, 1'b0, 2'd1, 32'h0, 1'b1, 32'h1, 2'd1, 4'd4},
    '{32'h2200_0278, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0, 2'd1, 4'd4},
    '{32'h2200_0258, 1'b0, 2'd1, 32'h0, 1'b1, 32'h1, 2'd1, 4'd3},
    '{32'h2200_0248, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0, 2'd1, 4'd3},
    // R3 R4 word alias reads of 0x20000010
    '{32'h2200_0274, 1'b0, 2'd2, 32'h0, 1'b1, 32'h1, 2'd1, 4'd4},
    '{32'h2200_0224, 1'b0, 2'd2, 32'h0, 1'b1, 32'h1, 2'd1, 4'd3},
    '{32'h2200_0230, 1'b0, 2'd2, 32'h0, 1'b1, 32'h0, 2'd1, 4'd3},
    // R6 R7 alias writes in window 1 on word 0x40000020
    '{32'h4200_0400, 1'b1, 2'd0, 32'h0000_0001, 1'b0, 32'h0, 2'd2, 4'd6},
    '{32'h4200_041C, 1'b1, 2'd2, 32'hFFFF_FFFE, 1'b0, 32'h0, 2'd2, 4'd7},
    '{32'h4200_0424, 1'b1, 2'd1, 32'h0000_0003, 1'b0, 32'h0, 2'd2, 4'd6},
    '{32'h4200_0450, 1'b1, 2'd0, 32'h0000_0000, 1'b0, 32'h0, 2'd2, 4'd6},
    '{32'h4200_047C, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0, 2'd2, 4'd6},
    '{32'h2200_0230, 1'b1, 2'd0, 32'h0000_0003, 1'b0, 32'h0, 2'd2, 4'd7},
    // R6 results seen through plain reads, R9 readback of R1 edge addresses
    '{32'h4000_0020, 1'b0, 2'd2, 32'h0, 1'b1, 32'h80EF_0271, 2'd1, 4'd6},
    '{32'h2000_0010, 1'b0, 2'd2, 32'h0, 1'b1, 32'hA5C3_1F81, 2'd1, 4'd6},
    '{32'h2400_0000, 1'b0, 2'd2, 32'h0, 1'b1, 32'h1234_5678, 2'd1, 4'd1},
    '{32'h21FF_FFFC, 1'b0, 2'd2, 32'h0, 1'b1, 32'hCAFE_F00D, 2'd1, 4'd1},
    // R3 R4 alias reads after the writes
    '{32'h4200_0424, 1'b0, 2'd0, 32'h0, 1'b1, 32'h1, 2'd1, 4'd3},
    '{32'h4200_0450, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0, 2'd1, 4'd4},
    '{32'h4200_0404, 1'b0, 2'd2, 32'h0, 1'b1, 32'h0, 2'd1, 4'd4},
    '{32'h4200_041C, 1'b0, 2'd0, 32'h0, 1'b1, 32'h0, 2'd1, 4'd7}
  };

  // ---------------- main sequence ---------------------------------------------
  initial begin
    logic [31:0] rd;
    int          ntx;
    logic        we0, we1;
    bit          leak;
    string       tag;

    rst_n = 1'b0; s_valid = 1'b0; s_addr = '0; s_we = 1'b0; s_size = 2'd0; s_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!m_valid, "R10", "m_valid in reset", 32'(m_valid), 32'h0);
    check(!s_rsp_valid, "R10", "s_rsp_valid in reset", 32'(s_rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);   // R11 second pass under memory back-pressure
      for (int v = 0; v < NV; v++) begin
        run_op(VEC[v].addr, VEC[v].we, VEC[v].size, VEC[v].wdata, rd, ntx, we0, we1, leak);
        tag = $sformatf("R%0d", VEC[v].req);
        if (VEC[v].chk)
          check(rd == VEC[v].exp, tag, $sformatf("read data vec %0d pass %0d", v, pass),
                rd, VEC[v].exp);
        // R8 no acceptance while busy
        check(!leak, "R8", $sformatf("s_ready high while busy vec %0d", v), 32'(leak), 32'h0);
        // R5 R6 R9 transaction count
        check(ntx == int'(VEC[v].ntx), tag, $sformatf("memory txn count vec %0d", v),
              32'(ntx), 32'(VEC[v].ntx));
        if (ntx == 2)  // R6 read then write
          check(!we0 && we1, "R6", $sformatf("rmw order vec %0d", v),
                {30'h0, we0, we1}, 32'h1);
        else if (ntx == 1)
          check(we0 == VEC[v].we, tag, $sformatf("forwarded direction vec %0d", v),
                32'(we0), 32'(VEC[v].we));
      end
    end

    // R10 reset in the middle of an alias write: no write-back may happen
    stall_mode = 1'b0;
    s_valid = 1'b1; s_addr = 32'h4200_0400; s_we = 1'b1; s_size = 2'd0; s_wdata = 32'h0;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!m_valid, "R10", "m_valid after mid-op reset", 32'(m_valid), 32'h0);
    check(!s_rsp_valid, "R10", "s_rsp_valid after mid-op reset", 32'(s_rsp_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(32'h4200_0400, 1'b0, 2'd0, 32'h0, rd, ntx, we0, we1, leak);
    check(rd == 32'h1, "R10", "bit unchanged after aborted write", rd, 32'h1);
    check(ntx == 1, "R5", "one read after reset", 32'(ntx), 32'h1);

    // R7 upper write-data bits ignored: 0xFFFFFFFE clears, then read back
    run_op(32'h4200_0400, 1'b1, 2'd2, 32'hFFFF_FFFE, rd, ntx, we0, we1, leak);
    run_op(32'h4000_0020, 1'b0, 2'd2, 32'h0, rd, ntx, we0, we1, leak);
    check(rd == 32'h80EF_0270, "R7", "clear with high bits set", rd, 32'h80EF_0270);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule